// File: doc/BRIEF.md
# Bit test-and-modify unit

This block examines one bit of a 32-bit operand and, in the same step, can leave it alone, invert it, force it low or force it high. The bit is named by a bit number that comes either from an 8-bit immediate field or from a 32-bit register value. The caller also chooses the operand size. A full 32-bit register operand uses the bit number modulo 32. A byte operand fetched from memory uses it modulo 8.

Every accepted request reports the state of the chosen bit as it was before any change. The report is a Zero-flag value, which is the inverse of that bit, plus a write enable for the Zero flag only. The modified operand comes out alongside it. Address calculation and the memory access are done elsewhere. For a byte operand, the caller places the byte in bits 7:0 and reads the result back from the same bits. A request is accepted when `in_valid` is high, and its results are registered on the next rising clock edge.

Top module: `bit_tam_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `zf_we`, `zf_value` and `result` all become 0.
- R2: A request with `in_valid` high at a rising edge yields `out_valid` = 1 and `zf_we` = 1 after that edge, so results arrive one cycle after the request.
- R3: When `idx_from_reg` = 0 the bit number is `imm_idx`, and `reg_idx` has no effect. When it is 1 the bit number is `reg_idx`, and `imm_idx` has no effect.
- R4: When `size_byte` = 0 (32-bit operand) the addressed bit is the bit number modulo 32.
- R5: When `size_byte` = 1 (byte operand) the addressed bit is the bit number modulo 8, and `result[31:8]` equals `operand[31:8]`.
- R6: `zf_value` is the inverse of the addressed bit of `operand` before any modification, for every operation code.
- R7: With `op` = 2'b00 (test) `result` equals `operand`.
- R8: With `op` = 2'b01 (invert) `result` equals `operand` with the addressed bit inverted.
- R9: With `op` = 2'b10 (clear) `result` equals `operand` with the addressed bit forced to 0.
- R10: With `op` = 2'b11 (set) `result` equals `operand` with the addressed bit forced to 1.
- R11: A rising edge with `in_valid` low drives `out_valid` and `zf_we` to 0 and leaves `result` and `zf_value` unchanged.
- R12: `result` differs from the request's `operand` in at most one bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 32 | Operand value; a byte operand sits in bits 7:0 |
| idx_from_reg | input | 1 | 0: bit number from `imm_idx`, 1: from `reg_idx` |
| imm_idx | input | 8 | Immediate bit number |
| reg_idx | input | 32 | Register-supplied bit number |
| size_byte | input | 1 | 0: 32-bit operand, 1: byte operand |
| op | input | 2 | 00 test, 01 invert, 10 clear, 11 set |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Operand after modification |
| zf_value | output | 1 | Zero flag: inverse of the bit before modification |
| zf_we | output | 1 | Write enable for the Zero flag only |

## Verification
The bench runs every operation code against both sizes and both bit-number sources, for bit numbers 0 through 63 and several operand patterns. This hits the wrap points where a design that forgot the modulo would touch a missing bit or the wrong byte bit. The unused bit-number source is held at a conflicting value, so that a design with a swapped source multiplexer addresses the wrong bit. The register source also carries large upper bits, which would expose a wrap that looks past the low five bits. Operands of all ones and all zeros catch a Zero flag sampled after the change rather than before it. Idle cycles between requests catch outputs that fail to hold or a write enable that stays high.

// File: rtl/bit_tam_pkg.sv
package bit_tam_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned IMM_W  = 8;

    typedef enum logic [1:0] {
        OP_TEST  = 2'b00,
        OP_FLIP  = 2'b01,
        OP_CLEAR = 2'b10,
        OP_SET   = 2'b11
    } bit_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              pre_bit;
    } bit_res_t;

    // Apply one operation to a word, given a one-hot mask of the target bit
    function automatic logic [DATA_W-1:0] apply_op(
        input logic [DATA_W-1:0] word,
        input logic [DATA_W-1:0] mask,
        input bit_op_e           op
    );
        logic [DATA_W-1:0] r;
        unique case (op)
            OP_TEST:  r = word;
            OP_FLIP:  r = word ^ mask;
            OP_CLEAR: r = word & ~mask;
            OP_SET:   r = word | mask;
            default:  r = word;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bit_index_sel.sv
module bit_index_sel
    import bit_tam_pkg::*;
#(
    parameter int unsigned D_W = DATA_W,
    parameter int unsigned B_W = BYTE_W,
    parameter int unsigned I_W = IMM_W,
    localparam int unsigned IDX_W  = $clog2(D_W),
    localparam int unsigned BIDX_W = $clog2(B_W)
) (
    input  logic              from_reg,
    input  logic [I_W-1:0]    imm_num,
    input  logic [D_W-1:0]    reg_num,
    input  logic              size_byte,
    output logic [IDX_W-1:0]  idx
);

    logic [IDX_W-1:0] raw;

    always_comb begin
        raw = from_reg ? reg_num[IDX_W-1:0] : imm_num[IDX_W-1:0];
        if (size_byte)
            idx = {{(IDX_W-BIDX_W){1'b0}}, raw[BIDX_W-1:0]};
        else
            idx = raw;
    end

endmodule

// File: rtl/bit_mask_gen.sv
module bit_mask_gen
    import bit_tam_pkg::*;
#(
    parameter int unsigned D_W = DATA_W,
    localparam int unsigned IDX_W = $clog2(D_W)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [D_W-1:0]   mask
);

    for (genvar i = 0; i < D_W; i++) begin : g_dec
        assign mask[i] = (idx == IDX_W'(i));
    end

endmodule

// File: rtl/bit_apply.sv
module bit_apply
    import bit_tam_pkg::*;
#(
    parameter int unsigned D_W = DATA_W
) (
    input  logic [D_W-1:0] word,
    input  logic [D_W-1:0] mask,
    input  bit_op_e        op,
    output bit_res_t       res
);

    always_comb begin
        res.pre_bit = |(word & mask);
        res.value   = apply_op(word, mask, op);
    end

endmodule

// File: rtl/bit_tam_unit.sv
module bit_tam_unit
    import bit_tam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic              idx_from_reg,
    input  logic [IMM_W-1:0]  imm_idx,
    input  logic [DATA_W-1:0] reg_idx,
    input  logic              size_byte,
    input  logic [1:0]        op,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              zf_value,
    output logic              zf_we
);

    localparam int unsigned IDX_W = $clog2(DATA_W);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mask;
    bit_res_t          res;

    bit_index_sel #(.D_W(DATA_W), .B_W(BYTE_W), .I_W(IMM_W)) u_sel (
        .from_reg (idx_from_reg),
        .imm_num  (imm_idx),
        .reg_num  (reg_idx),
        .size_byte(size_byte),
        .idx      (idx)
    );

    bit_mask_gen #(.D_W(DATA_W)) u_mask (
        .idx (idx),
        .mask(mask)
    );

    bit_apply #(.D_W(DATA_W)) u_apply (
        .word(operand),
        .mask(mask),
        .op  (bit_op_e'(op)),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            zf_we     <= 1'b0;
            zf_value  <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            zf_we     <= in_valid;
            if (in_valid) begin
                result   <= res.value;
                zf_value <= ~res.pre_bit;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && !zf_we && result == '0 && !zf_value)); // R1

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_valid && zf_we)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !zf_we && $stable(result) && $stable(zf_value))); // R11

    AST_TEST_UNCHANGED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00) |=> result == $past(operand)); // R7

    AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_byte) |=> result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W])); // R5

    AST_AT_MOST_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $countones(result ^ $past(operand)) <= 1); // R12

endmodule

// File: tb/bit_tam_unit_tb.sv
module bit_tam_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] operand;
    logic        idx_from_reg;
    logic [7:0]  imm_idx;
    logic [31:0] reg_idx;
    logic        size_byte;
    logic [1:0]  op;
    logic        out_valid;
    logic [31:0] result;
    logic        zf_value;
    logic        zf_we;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bit_tam_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .idx_from_reg(idx_from_reg), .imm_idx(imm_idx), .reg_idx(reg_idx),
        .size_byte(size_byte), .op(op), .out_valid(out_valid),
        .result(result), .zf_value(zf_value), .zf_we(zf_we)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [31:0] pattern(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'hA5C3_0F96;
            default: return 32'h5A3C_F069;
        endcase
    endfunction

    initial begin
        rst = 1'b1; in_valid = 1'b0; operand = 32'hDEAD_BEEF;
        idx_from_reg = 1'b0; imm_idx = 8'd0; reg_idx = '0;
        size_byte = 1'b0; op = 2'b00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {31'b0, out_valid}, 32'd0);
        check("R1 zf_we", {31'b0, zf_we}, 32'd0);
        check("R1 result", result, 32'd0);
        rst = 1'b0;

        for (int o = 0; o < 4; o++)
        for (int s = 0; s < 2; s++)
        for (int src = 0; src < 2; src++)
        for (int k = 0; k < 4; k++)
        for (int n = 0; n < 64; n++) begin
            logic [31:0] w, m, exp;
            int idx;
            logic pre;
            w = pattern(k) ^ (32'h0101_0101 * n[7:0]);
            idx = s ? (n % 8) : (n % 32);  // R4 R5
            m = 32'h1 << idx;
            pre = w[idx];
            case (o)
                0: exp = w;          // R7
                1: exp = w ^ m;      // R8
                2: exp = w & ~m;     // R9
                default: exp = w | m; // R10
            endcase
            in_valid = 1'b1; operand = w; op = o[1:0]; size_byte = s[0];
            idx_from_reg = src[0];
            if (src == 1) begin
                // R3: immediate holds a conflicting number
                reg_idx = 32'(n) + 32'h0F00_0040 * (k + 1);
                imm_idx = 8'(n + 3);
            end else begin
                imm_idx = 8'(n) + 8'd64 * 8'(k);
                reg_idx = 32'(n + 5);
            end
            @(negedge clk);
            check("R2 out_valid", {31'b0, out_valid}, 32'd1);
            check("R2 zf_we", {31'b0, zf_we}, 32'd1);
            check(o == 0 ? "R7 result" : o == 1 ? "R8 result" :
                  o == 2 ? "R9 result" : "R10 result", result, exp);
            check("R6 zf_value", {31'b0, zf_value}, {31'b0, ~pre});
            if (s == 1) check("R5 upper", result & 32'hFFFF_FF00, w & 32'hFFFF_FF00);
            if (n % 16 == 0) begin
                // R11: idle cycle with changed inputs
                in_valid = 1'b0; operand = ~w; op = 2'b11;
                @(negedge clk);
                check("R11 out_valid", {31'b0, out_valid}, 32'd0);
                check("R11 zf_we", {31'b0, zf_we}, 32'd0);
                check("R11 result", result, exp);
                check("R11 zf_value", {31'b0, zf_value}, {31'b0, ~pre});
            end
        end

        // R1: reset mid-run clears the outputs
        in_valid = 1'b1; operand = 32'hFFFF_FFFF; op = 2'b00;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 result after reset", result, 32'd0);
        check("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule